// File: doc/BRIEF.md
# Serial Flash Program and Read Sequencer

This block drives a single-lane serial flash over a four-wire link in clock mode 0. It runs a whole page-program operation or a whole read operation from one request, so software never steps through the individual commands. A request gives a 24-bit flash address, a byte count and a direction.

For a program request the block runs the following steps in order:
- It sends the write-enable opcode in a frame of its own.
- It opens a second frame carrying the page-program opcode, the address and the payload. The payload bytes come from a write port, and each byte is acknowledged as it is taken.
- It reads the status register, one frame per read, until the write-in-progress flag clears.
- If the flag is still set after a set number of status reads, it ends the operation with an error.

For a read request it sends the read opcode and the address, then clocks in the requested number of bytes. Each byte appears on a read port with a one-cycle valid strobe.

Chip-select always goes high for at least a set number of clock cycles between two frames. No byte is started while the previous byte is still being shifted. Each operation ends with a one-cycle completion pulse and an error flag that qualifies it.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, and `busy`, `done`, `err`, `rd_valid` and `wr_take` are all low.
- R2: Bits move MSB first, with the serial clock idling low. Each bit takes two system clocks, and the device samples on the rising edge. Chip-select only changes while the serial clock is low.
- R3: A program request first sends a frame that holds only the byte 0x06. Chip-select goes high right after that byte.
- R4: The second frame of a program request is 0x02, then the address MSB first (bits 23:16, 15:8, 7:0), then exactly `op_len` bytes from `wr_data`. Chip-select stays low for the whole frame. `wr_take` pulses once for each byte taken.
- R5: After the program frame, the block sends status frames. Each is 0x05 followed by one received byte. It sends a new one while bit 0 of the received status is 1, and stops at the first status whose bit 0 is 0. The other status bits are ignored.
- R6: If POLL_LIMIT status reads in a row all show bit 0 set, the operation ends with `err`=1. When the last allowed read shows bit 0 clear, the operation ends with `err`=0.
- R7: A read request sends one frame: 0x03, the address MSB first, then `op_len` dummy bytes. Each received byte is presented in order on `rd_data` with a one-cycle `rd_valid`.
- R8: `done` is high for exactly one cycle per operation, and `err` is only high together with `done`. `busy` is high from the cycle after acceptance until `done`.
- R9: `op_start` is ignored while `busy` is high. It neither changes the running operation nor queues a new one.
- R10: No byte transfer starts while the previous one is still shifting. Chip-select is low whenever a byte is shifting. Between frames, chip-select stays high for at least GAP_CYCLES clocks.
- R11: With `op_len`=0, a program frame carries only the opcode and the address, and polling follows as usual. A read frame carries only the opcode and the address, produces no `rd_valid`, and then completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Request strobe, accepted when idle |
| op_is_read | input | 1 | 1 selects read, 0 selects program |
| op_addr | input | 24 | Flash byte address |
| op_len | input | LEN_W | Number of payload bytes |
| wr_data | input | 8 | Next payload byte for program |
| wr_take | output | 1 | Payload byte consumed this cycle |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | `rd_data` valid strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with `done` |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The embedded properties watch the link discipline on every cycle:
- no byte starts while the shifter is busy;
- chip-select is low during shifting and changes only while the serial clock is low;
- chip-select is high whenever the sequencer is idle;
- `done` is a single-cycle pulse and `err` never appears without it;
- the poll count stays within its limit.

The bench runs a device model that decodes each frame from the pins and answers status and read commands. Its scenarios are the only way to show the following:
- the content and order of the frames;
- address byte order;
- how payload is taken and returned;
- the number of polls against the busy time of the model;
- the timeout boundary, zero-length requests and ignored requests.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_STAT,
        ST_GAP
    } seq_state_e;

    typedef enum logic [1:0] {
        K_WREN,
        K_PROG,
        K_POLL,
        K_READ
    } cmd_kind_e;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_STAT = 8'h05;
    localparam logic [7:0] OPC_READ = 8'h03;

    function automatic logic [7:0] opcode_of(cmd_kind_e k);
        case (k)
            K_WREN:  return OPC_WREN;
            K_PROG:  return OPC_PROG;
            K_POLL:  return OPC_STAT;
            default: return OPC_READ;
        endcase
    endfunction

endpackage

// File: rtl/flash_byte_shifter.sv
module flash_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rx_o,
    output logic              sck_o,
    output logic              mosi_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              active;
        logic              phase;
        logic [CNT_W-1:0]  bits;
        logic [BYTE_W-1:0] sh;
        logic              done;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start_i) begin
                d.active = 1'b1;
                d.phase  = 1'b0;
                d.bits   = '0;
                d.sh     = tx_i;
            end
        end else if (!q.phase) begin
            d.phase = 1'b1;
        end else begin
            d.phase = 1'b0;
            d.sh    = {q.sh[BYTE_W-2:0], miso_i};
            d.bits  = q.bits + 1'b1;
            if (q.bits == CNT_W'(BYTE_W - 1)) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.active;
    assign done_o = q.done;
    assign rx_o   = q.sh;
    assign sck_o  = q.active & q.phase;
    assign mosi_o = q.sh[BYTE_W-1];

    // R10: a new byte is never launched into a shifter that is still running
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.active) else $error("shifter restarted while busy");

    // R2: completion follows a high serial-clock phase
    assert_done_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sck_o)) else $error("done without final clock phase");

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int LEN_W      = 9,
    parameter int POLL_LIMIT = 1000,
    parameter int GAP_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_is_read,
    input  logic [23:0]      op_addr,
    input  logic [LEN_W-1:0] op_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W  = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        seq_state_e       state;
        cmd_kind_e        kind;
        logic             is_read;
        logic [23:0]      addr;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic [POLL_W-1:0] polls;
        logic [GAP_W-1:0] gap;
        logic             issued;
        logic             cs_n;
        logic             done;
        logic             err;
        logic             rd_valid;
        logic [7:0]       rd_data;
    } seq_t;

    seq_t q, d;

    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_tx, eng_rx;
    logic       take;
    logic [LEN_W-1:0]  cnt_inc;
    logic [POLL_W-1:0] poll_inc;

    flash_byte_shifter #(.BYTE_W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .tx_i    (eng_tx),
        .miso_i  (spi_miso),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .rx_o    (eng_rx),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.err      = 1'b0;
        d.rd_valid = 1'b0;
        eng_start  = 1'b0;
        eng_tx     = '0;
        take       = 1'b0;
        cnt_inc    = q.cnt + 1'b1;
        poll_inc   = q.polls + 1'b1;
        unique case (q.state)
            ST_IDLE: begin
                if (op_start) begin
                    d.is_read = op_is_read;
                    d.addr    = op_addr;
                    d.len     = op_len;
                    d.polls   = '0;
                    d.kind    = op_is_read ? K_READ : K_WREN;
                    d.issued  = 1'b0;
                    d.state   = ST_CMD;
                end
            end
            ST_GAP: begin
                d.gap = q.gap + 1'b1;
                if (q.gap == GAP_W'(GAP_CYCLES - 1)) d.state = ST_CMD;
            end
            default: begin
                if (!q.issued && !eng_busy) begin
                    eng_start = 1'b1;
                    d.issued  = 1'b1;
                    d.cs_n    = 1'b0;
                    case (q.state)
                        ST_CMD:   eng_tx = opcode_of(q.kind);
                        ST_ADDR:  case (q.cnt[1:0])
                                      2'd0:    eng_tx = q.addr[23:16];
                                      2'd1:    eng_tx = q.addr[15:8];
                                      default: eng_tx = q.addr[7:0];
                                  endcase
                        ST_WDATA: begin eng_tx = wr_data; take = 1'b1; end
                        default:  eng_tx = 8'h00;
                    endcase
                end else if (eng_done) begin
                    d.issued = 1'b0;
                    case (q.state)
                        ST_CMD: begin
                            d.cnt = '0;
                            if (q.kind == K_WREN) begin
                                d.cs_n = 1'b1; d.gap = '0; d.state = ST_GAP; d.kind = K_PROG;
                            end else if (q.kind == K_POLL) begin
                                d.state = ST_STAT;
                            end else begin
                                d.state = ST_ADDR;
                            end
                        end
                        ST_ADDR: begin
                            d.cnt = cnt_inc;
                            if (q.cnt[1:0] == 2'd2) begin
                                d.cnt = '0;
                                if (q.len != '0)   d.state = q.is_read ? ST_RDATA : ST_WDATA;
                                else if (q.is_read) begin
                                    d.cs_n = 1'b1; d.done = 1'b1; d.state = ST_IDLE;
                                end else begin
                                    d.cs_n = 1'b1; d.gap = '0; d.state = ST_GAP; d.kind = K_POLL;
                                end
                            end
                        end
                        ST_WDATA: begin
                            d.cnt = cnt_inc;
                            if (cnt_inc == q.len) begin
                                d.cs_n = 1'b1; d.gap = '0; d.state = ST_GAP; d.kind = K_POLL;
                            end
                        end
                        ST_RDATA: begin
                            d.cnt      = cnt_inc;
                            d.rd_valid = 1'b1;
                            d.rd_data  = eng_rx;
                            if (cnt_inc == q.len) begin
                                d.cs_n = 1'b1; d.done = 1'b1; d.state = ST_IDLE;
                            end
                        end
                        default: begin
                            d.polls = poll_inc;
                            d.cs_n  = 1'b1;
                            if (!eng_rx[0]) begin
                                d.done = 1'b1; d.state = ST_IDLE;
                            end else if (poll_inc == POLL_W'(POLL_LIMIT)) begin
                                d.done = 1'b1; d.err = 1'b1; d.state = ST_IDLE;
                            end else begin
                                d.gap = '0; d.state = ST_GAP; d.kind = K_POLL;
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_take  = take;
    assign rd_data  = q.rd_data;
    assign rd_valid = q.rd_valid;
    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign spi_cs_n = q.cs_n;

    // R1: the link is deselected whenever the sequencer is idle
    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> spi_cs_n) else $error("cs low while idle");

    // R10: chip-select held low for every shifting cycle
    assert_cs_during_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !spi_cs_n) else $error("shifting with cs high");

    // R2: chip-select edges only while the serial clock is low
    assert_cs_edge_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> !spi_sck) else $error("cs edge with sck high");

    // R8: completion is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle");

    // R8: error only alongside completion
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done) else $error("err without done");

    // R6: poll count never passes its limit
    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls <= POLL_W'(POLL_LIMIT)) else $error("poll count over limit");

    // R7: received bytes only appear for read operations
    assert_rd_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> q.is_read) else $error("rd_valid during program");

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
    localparam int LEN_W = 9;
    localparam int PLIM  = 5;
    localparam int GAPC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, op_is_read = 1'b0;
    logic [23:0] op_addr = '0;
    logic [LEN_W-1:0] op_len = '0;
    logic [7:0] wr_data, rd_data;
    logic wr_take, rd_valid, busy, done, err, spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #4 clk = ~clk;

    flash_prog_seq #(.LEN_W(LEN_W), .POLL_LIMIT(PLIM), .GAP_CYCLES(GAPC)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_read(op_is_read),
        .op_addr(op_addr), .op_len(op_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] wpat(input int i);
        return 8'(i * 37 + 17);
    endfunction

    // payload source
    int wr_idx = 0;
    assign wr_data = wpat(wr_idx);
    always @(posedge clk) if (wr_take) wr_idx <= wr_idx + 1;

    // read and done capture
    logic [7:0] rd_log [0:255];
    int rd_n = 0, done_n = 0;
    logic last_err = 1'b0;
    always @(posedge clk) begin
        if (rd_valid) begin rd_log[rd_n] <= rd_data; rd_n <= rd_n + 1; end
        if (done) begin done_n <= done_n + 1; last_err <= err; end
    end

    // flash device model, sampled on the system clock
    int cfg_busy = 0;
    logic [7:0] log_b [0:1023];
    int frame_start [0:127];
    int frame_len [0:127];
    int log_n = 0, frame_n = 0;
    int min_gap = 1000, gap_run = 0;
    bit seen_frame = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    int bitc = 0, bytec = 0, stat_seen = 0;
    logic [7:0] ish = '0, cmd = '0, osh = '0;
    logic [23:0] maddr = '0;

    always @(posedge clk) begin
        if (prev_cs && !spi_cs_n) begin
            bitc = 0; bytec = 0; osh = '0;
            frame_start[frame_n] = log_n;
            if (seen_frame && gap_run < min_gap) min_gap = gap_run;
        end
        if (!prev_cs && spi_cs_n) begin
            frame_len[frame_n] = log_n - frame_start[frame_n];
            frame_n = frame_n + 1;
            seen_frame = 1; gap_run = 0;
        end
        if (spi_cs_n) gap_run = gap_run + 1;
        if (!spi_cs_n && spi_sck && !prev_sck) begin
            ish = {ish[6:0], spi_mosi};
            bitc = bitc + 1;
            if (bitc == 8) begin
                bitc = 0;
                log_b[log_n] = ish; log_n = log_n + 1;
                if (bytec == 0) cmd = ish;
                else if (bytec <= 3) maddr = {maddr[15:0], ish};
                bytec = bytec + 1;
                if (bytec == 1 && ish == 8'h06) stat_seen = 0;
                if (cmd == 8'h05 && bytec == 1) begin
                    osh = (stat_seen < cfg_busy) ? 8'h03 : 8'h02;
                    stat_seen = stat_seen + 1;
                end else if (cmd == 8'h03 && bytec >= 4) osh = rpat(maddr + 24'(bytec - 4));
                else osh = '0;
            end
        end
        if (!spi_sck && prev_sck) begin
            spi_miso <= osh[7];
            osh = {osh[6:0], 1'b0};
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    // stimulus table: {is_read, addr, len, busy_polls}
    localparam int NV = 8;
    localparam logic [37:0] VEC [0:NV-1] = '{
        {1'b0, 24'h123456, 9'd4, 4'd0},
        {1'b0, 24'hABCDEF, 9'd3, 4'd2},
        {1'b1, 24'h00FF10, 9'd5, 4'd0},
        {1'b0, 24'h0001FE, 9'd1, 4'd4},
        {1'b0, 24'h55AA00, 9'd2, 4'd9},
        {1'b1, 24'h7A0000, 9'd0, 4'd0},
        {1'b0, 24'h300000, 9'd0, 4'd1},
        {1'b1, 24'hFFFFFE, 9'd4, 4'd0}
    };

    bit hung = 0;

    task automatic run_vec(input logic [37:0] v, input bit poke_busy);
        logic isr; logic [23:0] a; int len, bz;
        int f0, w0, r0, d0, nf, nb, polls, wait_c;
        bit exp_err, ok;
        logic [7:0] eb [0:63];
        int el [0:15];
        isr = v[37]; a = v[36:13]; len = int'(v[12:4]); bz = int'(v[3:0]);
        f0 = frame_n; w0 = wr_idx; r0 = rd_n; d0 = done_n;
        cfg_busy = bz;
        @(negedge clk);
        op_start = 1'b1; op_is_read = isr; op_addr = a; op_len = LEN_W'(len);
        @(negedge clk);
        op_start = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
        wait_c = 0;
        while (done_n == d0 && wait_c < 20000) begin
            @(negedge clk);
            wait_c++;
            if (poke_busy && wait_c == 60) begin
                op_start = 1'b1; op_is_read = 1'b1; op_addr = 24'h0F0F0F; op_len = 9'd2;
            end
            if (poke_busy && wait_c == 61) op_start = 1'b0;
        end
        if (done_n == d0) begin hung = 1; check(0, "R8 watchdog", 0, 1); return; end
        repeat (4) @(negedge clk);
        nf = 0; nb = 0;
        exp_err = 0;
        if (isr) begin
            el[0] = 4 + len; nf = 1;
            eb[nb++] = 8'h03; eb[nb++] = a[23:16]; eb[nb++] = a[15:8]; eb[nb++] = a[7:0];
            for (int i = 0; i < len; i++) eb[nb++] = 8'h00;
        end else begin
            polls = (bz + 1 > PLIM) ? PLIM : bz + 1;
            exp_err = (bz + 1 > PLIM);
            el[nf++] = 1; eb[nb++] = 8'h06;
            el[nf++] = 4 + len;
            eb[nb++] = 8'h02; eb[nb++] = a[23:16]; eb[nb++] = a[15:8]; eb[nb++] = a[7:0];
            for (int i = 0; i < len; i++) eb[nb++] = wpat(w0 + i);
            for (int p = 0; p < polls; p++) begin el[nf++] = 2; eb[nb++] = 8'h05; eb[nb++] = 8'h00; end
        end
        // R3 R4 R5 R7 R11: frame structure as seen on the pins
        ok = (frame_n - f0 == nf);
        check(ok, isr ? "R7/R11 read frame count" : "R3/R5 program frame count", frame_n - f0, nf);
        if (ok) begin
            int k;
            k = 0;
            for (int f = 0; f < nf; f++) begin
                if (frame_len[f0 + f] != el[f]) begin
                    check(0, "R4 frame length", frame_len[f0 + f], el[f]); ok = 0;
                end
                for (int j = 0; j < el[f] && ok; j++) begin
                    if (log_b[frame_start[f0 + f] + j] != eb[k + j]) begin
                        check(0, isr ? "R7 byte stream" : "R4 byte stream",
                              log_b[frame_start[f0 + f] + j], eb[k + j]);
                        ok = 0;
                    end
                end
                k += el[f];
            end
            if (ok) check(1, "R2 byte stream", 0, 0);
        end
        check(last_err == exp_err, "R6 error flag", last_err, exp_err);
        check(done_n - d0 == 1, "R8 single done", done_n - d0, 1);
        check(busy == 1'b0, "R8 busy cleared", busy, 0);
        if (isr) begin
            ok = (rd_n - r0 == len);
            for (int i = 0; i < len && ok; i++) if (rd_log[r0 + i] != rpat(a + 24'(i))) ok = 0;
            check(ok, "R7 read data", rd_n - r0, len);
        end else begin
            check(wr_idx - w0 == len, "R4 wr_take count", wr_idx - w0, len);
            check(rd_n == r0, "R7 no rd_valid on program", rd_n, r0);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int f_before;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(spi_cs_n == 1'b1, "R1 cs high in reset", spi_cs_n, 1);
        check(spi_sck == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 idle outputs in reset",
              {spi_sck, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sck && !busy && !done && !err && !rd_valid && !wr_take,
              "R1 idle after reset", {spi_cs_n, spi_sck, busy, done, err}, 5'b10000);
        for (int v = 0; v < NV && !hung; v++) run_vec(VEC[v], 1'b0);
        // R9: a request raised mid-operation changes nothing and starts nothing
        if (!hung) begin
            run_vec({1'b0, 24'h0BEEF0, 9'd3, 4'd1}, 1'b1);
            f_before = frame_n;
            repeat (300) @(negedge clk);
            check(frame_n == f_before && !busy, "R9 no queued operation", frame_n - f_before, 0);
        end
        // R10: inter-frame deselect time
        check(min_gap >= GAPC, "R10 minimum deselect gap", min_gap, GAPC);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule